// File: doc/BRIEF.md
# Bit-Serial Binary-Decomposed Vector-Matrix Array

This block multiplies a stored matrix of unsigned M x N elements, each IW bits wide, by an unsigned N-element input vector whose elements are JW bits wide. It never forms a full-word product. Each weight bit of each matrix row is kept as its own binary row of N bits, so the store holds M*IW binary rows.

The input vector is fed in one bit-plane per clock, least significant bit first. In every compute cycle, each binary row ANDs its stored bits with the current input bit-plane and counts the ones. It then passes that count through its own 6-bit quantizer. The quantized partial results for all rows come out together, tagged with the input-bit index j. The weight-bit index i and the output row m are given by the position of a field in the output word. A downstream stage combines the partials with weight 2^(i+j) to rebuild the full products.

Matrix bits arrive over two serial lanes: one fills the even columns and the other fills the odd columns. The input vector is written in parallel into a shift register. A start request then runs JW compute cycles and ends with a done pulse.

Top module: `bsvmm_array`

## Requirements
- R1: Each cycle with `ld_en` high while idle shifts `ld_even` into the even-column lane and `ld_odd` into the odd-column lane. After M*IW*N/2 such pulses, the bits given on pulse p (counted from 0) occupy binary row r = p / (N/2), columns 2c and 2c+1, where c = p mod (N/2). Binary row r = m*IW + i holds bit i of matrix element (m, column).
- R2: `vec_load` while idle copies `vec_data` into the input register, with element n at bits [n*JW +: JW]. That register resets to all zeros, so a start straight after reset gives all-zero partials.
- R3: A `start` sampled high while idle raises `busy` at that edge. `part_valid` is then high on the next JW edges, with `part_j` counting 0, 1, ..., JW-1, so bit j of every input element is used in partial j (LSB first).
- R4: In each valid partial, field r of `part_q` (bits [r*6 +: 6], r = m*IW + i) is the quantized count of columns n where bit i of W(m,n) and bit j of X(n) are both 1.
- R5: The quantizer right-shifts the count by max(0, ceil(log2(N+1)) - 6) bits and saturates at 63.
- R6: `done` is high for exactly one cycle, together with the partial for j = JW-1, and `busy` falls at that same edge.
- R7: While `busy` is high, `start`, `vec_load` and `ld_en` have no effect. The partials in progress are unchanged, no extra run follows, and the stored matrix is unchanged.
- R8: A run consumes the input register. A second start with no new `vec_load` gives all-zero partials.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Shift one bit into each matrix lane |
| ld_even | input | 1 | Serial bit for the even-column lane |
| ld_odd | input | 1 | Serial bit for the odd-column lane |
| vec_load | input | 1 | Capture the input vector |
| vec_data | input | N*JW | Input vector, element n at [n*JW +: JW] |
| start | input | 1 | Begin a run |
| busy | output | 1 | A run is in progress |
| part_valid | output | 1 | Partial outputs valid this cycle |
| part_j | output | max(1,ceil(log2 JW)) | Input-bit index of the partials |
| part_q | output | M*IW*6 | Quantized partial counts, one 6-bit field per binary row |
| done | output | 1 | Last partial of the run |

## Verification
A start driven before edge e0 makes `busy` visible just after e0. Partial j is due just after edge e(j+1), and `done` comes with partial JW-1 just after edge eJW. The bench drives inputs on falling edges and samples on the falling edge after each of these rising edges, so every check reads a value that has settled for half a period. Inputs fed in while busy are placed so that the design would sample them at e2. The partial at e3 and the next run then show whether those inputs leaked in.

// File: rtl/bsvmm_pkg.sv
// Package: shared helpers for the bit-serial vector-matrix array.
// Assumes elaboration-time constant arguments only.
package bsvmm_pkg;
    // Right shift the quantizer applies so an N-wide count fits in qw bits.
    function automatic int quant_shift(input int n, input int qw);
        int cw;
        cw = $clog2(n + 1);
        return (cw > qw) ? (cw - qw) : 0;
    endfunction

    // Sequencer states.
    typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/bsvmm_plane_store.sv
// Module: bit-plane weight store built from two serial lanes.
// The even lane fills even columns and the odd lane fills odd columns.
// A new bit enters at the top of each lane, so the first bit loaded
// ends at index 0. Loading is blocked while a run is active.
module bsvmm_plane_store #(
    parameter int ROWS = 4,
    parameter int HALF = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 even_bit,
    input  logic                 odd_bit,
    output logic [ROWS*HALF-1:0] lane_even,
    output logic [ROWS*HALF-1:0] lane_odd
);
    localparam int LEN = ROWS * HALF;

    // Shift both lanes together on each accepted load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_even <= '0;
            lane_odd  <= '0;
        end else if (shift_en) begin
            lane_even <= {even_bit, lane_even[LEN-1:1]};
            lane_odd  <= {odd_bit,  lane_odd[LEN-1:1]};
        end
    end
endmodule

// File: rtl/bsvmm_vec_serializer.sv
// Module: input vector register that shifts out one bit-plane per step.
// Element n lives at [n*JW +: JW]; bit 0 of each element is the
// current plane. Resets to zero, and a run leaves it at zero.
module bsvmm_vec_serializer #(
    parameter int N  = 8,
    parameter int JW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [N*JW-1:0] data,
    input  logic            step,
    output logic [N-1:0]    plane
);
    logic [N*JW-1:0] vec_q;

    // Load a fresh vector or shift every element right by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (load) begin
            vec_q <= data;
        end else if (step) begin
            for (int n = 0; n < N; n++) begin
                vec_q[n*JW +: JW] <= {1'b0, vec_q[n*JW+1 +: JW-1]};
            end
        end
    end

    // Pick the least significant bit of each element as the current plane.
    always_comb begin
        for (int n = 0; n < N; n++) begin
            plane[n] = vec_q[n*JW];
        end
    end
endmodule

// File: rtl/bsvmm_row_unit.sv
// Module: one binary row. It ANDs the stored bits with the input plane,
// counts the ones, quantizes the count to QW bits (shift, then
// saturate) and registers the result when enabled.
module bsvmm_row_unit #(
    parameter int N  = 8,
    parameter int QW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [N-1:0]  wrow,
    input  logic [N-1:0]  xplane,
    output logic [QW-1:0] q
);
    import bsvmm_pkg::*;

    localparam int CW   = $clog2(N + 1);
    localparam int SH   = quant_shift(N, QW);
    localparam int QMAX = (1 << QW) - 1;

    logic [N-1:0]  prod;
    logic [CW-1:0] cnt;
    logic [CW-1:0] scaled;
    logic [QW-1:0] q_next;

    // Binary products and their population count.
    always_comb begin
        prod = wrow & xplane;
        cnt  = '0;
        for (int n = 0; n < N; n++) begin
            cnt = cnt + CW'(prod[n]);
        end
    end

    // Quantizer: scale into range, then clip at full scale.
    always_comb begin
        scaled = cnt >> SH;
        if (int'(scaled) > QMAX) begin
            q_next = QW'(QMAX);
        end else begin
            q_next = QW'(scaled);
        end
    end

    // Hold the quantized partial for one output cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= q_next;
        end
    end
endmodule

// File: rtl/bsvmm_sequencer.sv
// Module: run control. It accepts start only when idle, steps the
// input-bit index over JW cycles and registers the valid, index and
// done outputs.
module bsvmm_sequencer #(
    parameter int JW = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    output logic                           busy,
    output logic                           valid,
    output logic [(JW>1?$clog2(JW):1)-1:0] j_out,
    output logic                           done
);
    import bsvmm_pkg::*;

    localparam int JBW = (JW > 1) ? $clog2(JW) : 1;
    localparam logic [JBW-1:0] JLAST = JBW'(JW - 1);

    seq_state_e     state;
    logic [JBW-1:0] jcnt;

    assign busy = (state == SEQ_RUN);

    // State and bit index: start only from idle, stop after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            jcnt  <= '0;
        end else if (state == SEQ_IDLE) begin
            if (start) begin
                state <= SEQ_RUN;
                jcnt  <= '0;
            end
        end else if (jcnt == JLAST) begin
            state <= SEQ_IDLE;
            jcnt  <= '0;
        end else begin
            jcnt <= jcnt + 1'b1;
        end
    end

    // Output strobes, aligned with the registered partials.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            done  <= 1'b0;
            j_out <= '0;
        end else begin
            valid <= busy;
            done  <= busy && (jcnt == JLAST);
            if (busy) begin
                j_out <= jcnt;
            end
        end
    end
endmodule

// File: rtl/bsvmm_array.sv
// Module: top of the bit-serial binary-decomposed vector-matrix array.
// It holds M*IW binary rows of N bits, with row r = m*IW + i carrying
// bit i of matrix row m. Each run streams JW input bit-planes, LSB
// first, and emits one quantized count per binary row per cycle.
// Assumes N is even (the two load lanes have equal length).
module bsvmm_array #(
    parameter int M  = 2,
    parameter int N  = 8,
    parameter int IW = 2,
    parameter int JW = 3,
    parameter int QW = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ld_en,
    input  logic                           ld_even,
    input  logic                           ld_odd,
    input  logic                           vec_load,
    input  logic [N*JW-1:0]                vec_data,
    input  logic                           start,
    output logic                           busy,
    output logic                           part_valid,
    output logic [(JW>1?$clog2(JW):1)-1:0] part_j,
    output logic [M*IW*QW-1:0]             part_q,
    output logic                           done
);
    localparam int ROWS = M * IW;
    localparam int HALF = N / 2;

    logic [ROWS*HALF-1:0] w_even;
    logic [ROWS*HALF-1:0] w_odd;
    logic [N-1:0]         xplane;

    bsvmm_sequencer #(.JW(JW)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .valid (part_valid),
        .j_out (part_j),
        .done  (done)
    );

    bsvmm_plane_store #(.ROWS(ROWS), .HALF(HALF)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (ld_en && !busy),
        .even_bit  (ld_even),
        .odd_bit   (ld_odd),
        .lane_even (w_even),
        .lane_odd  (w_odd)
    );

    bsvmm_vec_serializer #(.N(N), .JW(JW)) u_vec (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (vec_load && !busy),
        .data  (vec_data),
        .step  (busy),
        .plane (xplane)
    );

    // One row unit per binary row; interleave the two lanes into columns.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [N-1:0] wrow;
        for (genvar c = 0; c < HALF; c++) begin : g_col
            assign wrow[2*c]   = w_even[r*HALF + c];
            assign wrow[2*c+1] = w_odd[r*HALF + c];
        end
        bsvmm_row_unit #(.N(N), .QW(QW)) u_row (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (busy),
            .wrow   (wrow),
            .xplane (xplane),
            .q      (part_q[r*QW +: QW])
        );
    end
endmodule

// File: rtl/bsvmm_array_chk.sv
// Checker: temporal properties of the array, bound to the top module.
module bsvmm_array_chk #(
    parameter int M  = 2,
    parameter int N  = 8,
    parameter int IW = 2,
    parameter int JW = 3,
    parameter int QW = 6
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           ld_en,
    input logic                           busy,
    input logic                           part_valid,
    input logic [(JW>1?$clog2(JW):1)-1:0] part_j,
    input logic [M*IW*QW-1:0]             part_q,
    input logic                           done,
    input logic [M*IW*(N/2)-1:0]          w_even,
    input logic [M*IW*(N/2)-1:0]          w_odd
);
    import bsvmm_pkg::*;

    localparam int JBW  = (JW > 1) ? $clog2(JW) : 1;
    localparam int SH   = quant_shift(N, QW);
    localparam int QMAX = (1 << QW) - 1;
    localparam int QCAP = ((N >> SH) > QMAX) ? QMAX : (N >> SH);

    // R3: the first partial follows the edge after busy rises.
    p_first_partial_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> part_valid && part_j == '0);

    // R3: a valid partial only follows a busy cycle.
    p_valid_from_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        part_valid |-> $past(busy));

    // R3: consecutive partials step the bit index by one.
    p_index_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (part_valid && part_j != '0) |-> ($past(part_valid) && part_j == JBW'($past(part_j) + 1'b1)));

    // R6: done marks the last partial, and the run has ended.
    p_done_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (part_valid && part_j == JBW'(JW - 1) && !busy));

    // R6: busy only falls together with done.
    p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7: load pulses during a run leave the matrix untouched.
    p_store_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ld_en) |=> ($stable(w_even) && $stable(w_odd)));

    // R5: no quantized field exceeds the scaled column count.
    for (genvar r = 0; r < M*IW; r++) begin : g_bound
        p_quant_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
            part_valid |-> (int'(part_q[r*QW +: QW]) <= QCAP));
    end
endmodule

bind bsvmm_array bsvmm_array_chk #(.M(M), .N(N), .IW(IW), .JW(JW), .QW(QW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en      (ld_en),
    .busy       (busy),
    .part_valid (part_valid),
    .part_j     (part_j),
    .part_q     (part_q),
    .done       (done),
    .w_even     (w_even),
    .w_odd      (w_odd)
);

// File: tb/bsvmm_array_test.sv
// Bench: sweeps several matrix and vector patterns through a small array
// and computes every expected partial arithmetically.
module bsvmm_array_test;
    localparam int M = 2, N = 8, IW = 2, JW = 3, QW = 6;
    localparam int ROWS = M * IW;
    localparam int HALF = N / 2;
    localparam int JBW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_en = 1'b0, ld_even = 1'b0, ld_odd = 1'b0;
    logic vec_load = 1'b0, start = 1'b0;
    logic [N*JW-1:0] vec_data = '0;
    logic busy, part_valid, done;
    logic [JBW-1:0] part_j;
    logic [ROWS*QW-1:0] part_q;

    int wmat [M][N];
    int xvec [N];
    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bsvmm_array #(.M(M), .N(N), .IW(IW), .JW(JW), .QW(QW)) uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_even(ld_even), .ld_odd(ld_odd),
        .vec_load(vec_load), .vec_data(vec_data), .start(start), .busy(busy),
        .part_valid(part_valid), .part_j(part_j), .part_q(part_q), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected quantized count: shift is 0 for N = 8, clip at 63.
    function automatic int expect_q(input int r, input int j, input bit zero_x);
        int m, i, cnt;
        m = r / IW;
        i = r % IW;
        cnt = 0;
        for (int n = 0; n < N; n++) begin
            if (!zero_x && ((wmat[m][n] >> i) & 1) == 1 && ((xvec[n] >> j) & 1) == 1) cnt++;
        end
        return (cnt > 63) ? 63 : cnt;
    endfunction

    // R1: shift the matrix in, two lanes per pulse.
    task automatic load_matrix();
        for (int p = 0; p < ROWS*HALF; p++) begin
            int r, c, m, i;
            r = p / HALF; c = p % HALF; m = r / IW; i = r % IW;
            @(negedge clk);
            ld_en = 1'b1;
            ld_even = 1'((wmat[m][2*c] >> i) & 1);
            ld_odd  = 1'((wmat[m][2*c+1] >> i) & 1);
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // R2: write the vector in parallel.
    task automatic load_vector();
        @(negedge clk);
        vec_load = 1'b1;
        for (int n = 0; n < N; n++) vec_data[n*JW +: JW] = JW'(xvec[n]);
        @(negedge clk);
        vec_load = 1'b0;
    endtask

    // R3/R4/R6: run once and compare every partial; optionally disturb mid-run (R7).
    task automatic run_and_check(input bit zero_x, input bit disturb, input string tag);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R3 busy", int'(busy), 1);
        for (int k = 0; k < JW; k++) begin
            @(negedge clk);
            if (disturb) begin
                start = 1'b0; vec_load = 1'b0; ld_en = 1'b0;
            end
            check(part_valid == 1'b1, {tag, " R3 valid"}, int'(part_valid), 1);
            check(int'(part_j) == k, {tag, " R3 index"}, int'(part_j), k);
            for (int r = 0; r < ROWS; r++) begin
                int a, e;
                a = int'(part_q[r*QW +: QW]);
                e = expect_q(r, k, zero_x);
                check(a == e, {tag, " R4 R5 partial"}, a, e);
            end
            check(done == (k == JW-1), {tag, " R6 done"}, int'(done), int'(k == JW-1));
            if (k == JW-1) check(busy == 1'b0, {tag, " R6 busy end"}, int'(busy), 0);
            if (disturb && k == 0) begin
                start = 1'b1; vec_load = 1'b1; vec_data = '1;
                ld_en = 1'b1; ld_even = 1'b1; ld_odd = 1'b1;
            end
        end
        vec_load = 1'b0; ld_en = 1'b0;
        @(negedge clk);
        check(part_valid == 1'b0, {tag, " R7 no extra run"}, int'(part_valid), 0);
        check(done == 1'b0, {tag, " R6 single done"}, int'(done), 0);
        check(busy == 1'b0, {tag, " R7 idle after"}, int'(busy), 0);
    endtask

    task automatic set_pattern(input int kind);
        for (int m = 0; m < M; m++)
            for (int n = 0; n < N; n++)
                case (kind)
                    0: wmat[m][n] = 3;
                    1: wmat[m][n] = (m * 3 + n * 5) % 4;
                    2: wmat[m][n] = (n + m) % 2 == 0 ? 1 : 2;
                    default: wmat[m][n] = (n * 7 + m) % 4;
                endcase
        for (int n = 0; n < N; n++)
            case (kind)
                0: xvec[n] = 7;
                1: xvec[n] = n % 8;
                2: xvec[n] = (n * 3 + 1) % 8;
                default: xvec[n] = 7 - (n % 8);
            endcase
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "reset busy", int'(busy), 0);
        check(part_valid == 1'b0, "reset valid", int'(part_valid), 0);
        check(done == 1'b0, "reset done", int'(done), 0);
        check(part_q == '0, "reset partials", int'(part_q), 0);

        // R2: reset vector is zero, so the partials are zero for any matrix.
        set_pattern(0);
        load_matrix();
        run_and_check(1'b1, 1'b0, "R2 reset vector");

        // R1/R4: pattern sweep.
        for (int kind = 0; kind < 4; kind++) begin
            set_pattern(kind);
            load_matrix();
            load_vector();
            run_and_check(1'b0, 1'b0, "R1 sweep");
            // R8: a second start without a load sees a zero vector.
            run_and_check(1'b1, 1'b0, "R8 consumed");
        end

        // R7: start, vec_load and ld_en during a run are ignored.
        set_pattern(1);
        load_matrix();
        load_vector();
        run_and_check(1'b0, 1'b1, "R7 disturbed");
        // The matrix must still be the old one.
        load_vector();
        run_and_check(1'b0, 1'b0, "R7 matrix kept");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule